// File: doc/BRIEF.md
# Register-mapped serial port with parity

This block is an asynchronous serial transmitter and receiver sitting on a small 8-bit register bus. Software starts a transmission simply by writing a character to the data address; no separate start command exists. Incoming serial data is oversampled and assembled in a hidden shift register, and each finished character is moved into a read-only receive buffer in a single step. Frames carry one start bit, seven or eight data bits sent least significant bit first, an optional even or odd parity bit and one stop bit.

The timing base is a sample tick at sixteen times the bit rate. It comes from one of three sources: the system clock divided by a power of two (exponent 1 to 9), rising edges on an external clock pin, or rising edges of a timer pulse. Two interrupt outputs report a finished transmission and a newly loaded receive buffer. Parity, framing and overrun conditions are held in sticky status bits that clear when the status register is read.

Register map (2-bit address): 0 writes the transmit character and reads the receive buffer; 1 is the mode register, where bits [1:0] pick the tick source (0 divided clock, 1 external pin, 2 timer, 3 divided clock), bit 2 selects 7-bit characters, and bits [4:3] pick parity (0 none, 1 even, 2 odd, 3 none); 2 holds the divider exponent in bits [3:0] (reset value 1; 0 acts as 1, values above 9 act as 9); 3 is read-only status, where bit 0 is parity error, bit 1 framing error, bit 2 overrun, bit 3 transmitter busy and bit 4 unread receive data.

Top module: `sercom_uart`

## Requirements
- R1: A write to address 0 while the transmitter is idle drives txd low at once for a 16-tick start bit, then sends the data bits least significant bit first and a high stop bit, each 16 ticks long; txd idles high.
- R2: With bit 2 of the mode register set, only bits 0 to 6 of the written character go on the line and bit 7 has no effect.
- R3: With even parity one parity bit follows the data so that the count of ones in data plus parity is even; odd parity makes it odd; with no parity the stop bit follows the last data bit.
- R4: After reset the receive buffer reads 0xFF, the status register reads 0x00, the divider exponent reads 1, txd is high and both interrupt outputs are low (the transmit register also holds 0xFF).
- R5: Each completed received character is copied into the receive buffer and irq_rx is high for exactly one cycle, in the cycle the buffer first holds the new value.
- R6: In 7-bit mode the received data fills bits 0 to 6 of the receive buffer and bit 7 reads 0.
- R7: The sample tick is one per 2^k system cycles, one per rising edge of ext_sclk, or one per rising edge of tmr_pulse, as selected by mode bits [1:0]; one bit lasts 16 ticks on both paths.
- R8: A received parity bit that does not match the selected parity sets status bit 0; the bit stays set until status is read and the read clears it.
- R9: A received stop bit sampled low sets status bit 1, sticky until a status read; the character is still loaded.
- R10: A character completing while status bit 4 is still set sets status bit 2 and the buffer is overwritten with the new character; a read of address 0 clears bit 4.
- R11: The start bit is confirmed 8 ticks after the falling edge; a low pulse shorter than that loads nothing and raises no interrupt.
- R12: irq_tx is high for one cycle when the stop bit ends; status bit 3 reads 1 while a frame is being sent.
- R13: A write to address 0 during a transmission is ignored: the frame on the line and the character received from it are unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered one cycle after bus_rd |
| ext_sclk | input | 1 | External serial clock pin (asynchronous) |
| tmr_pulse | input | 1 | Timer output pulse |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit-complete pulse |
| irq_rx | output | 1 | Receive-complete pulse |

## Verification
The main path is tried with a table of characters sent through a loopback from txd to rxd, and each frame is also decoded bit by bit at its centre points against a frame built independently in the bench. The table mixes the 8-bit and 7-bit lengths, all three parity settings, and the three tick sources at different rates, so that a wrong bit order, a wrong parity sense, an ignored length bit or a wrong tick period each yield a different miscompare. Patterns such as 0xA5, 0x3C, 0xFF, 0x00 and 0x80 in 7-bit mode separate bit-order errors, parity polarity and the masking of bit 7. Directed serial streams driven by the bench then isolate the receive errors (bad parity, low stop bit, overrun, short start glitch), which loopback alone could never produce.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
  typedef enum logic [1:0] {
    SRC_DIV = 2'd0,
    SRC_PIN = 2'd1,
    SRC_TMR = 2'd2,
    SRC_ALT = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } fr_state_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
endpackage

// File: rtl/sercom_tick.sv
module sercom_tick
  import sercom_pkg::*;
#(
  parameter int DIV_MAX = 9,
  localparam int EW = $clog2(DIV_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  clk_src_e      src,
  input  logic [EW-1:0] div_exp,
  input  logic          ext_pin,
  input  logic          tmr_in,
  output logic          tick
);
  localparam int SW = DIV_MAX + 1;

  logic [DIV_MAX-1:0] cnt;
  logic [DIV_MAX-1:0] mask;
  logic [SW-1:0]      one_sh;
  logic [EW-1:0]      k_eff;
  logic [2:0]         pin_sy;
  logic               tmr_q;
  logic               pre_hit, pin_rise, tmr_rise;

  always_comb begin
    k_eff = div_exp;
    if (div_exp == '0) k_eff = EW'(1);
    else if (div_exp > EW'(DIV_MAX)) k_eff = EW'(DIV_MAX);
    one_sh = SW'(1) << k_eff;
    mask   = DIV_MAX'(one_sh - SW'(1));
  end

  assign pre_hit  = &(cnt | ~mask);
  assign pin_rise = pin_sy[1] & ~pin_sy[2];
  assign tmr_rise = tmr_in & ~tmr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      pin_sy <= '0;
      tmr_q  <= 1'b0;
      tick   <= 1'b0;
    end else begin
      cnt    <= cnt + 1'b1;
      pin_sy <= {pin_sy[1:0], ext_pin};
      tmr_q  <= tmr_in;
      case (src)
        SRC_PIN: tick <= pin_rise;
        SRC_TMR: tick <= tmr_rise;
        default: tick <= pre_hit;
      endcase
    end
  end

  // R7: every source yields isolated single-cycle ticks
  p_tick_isolated_r7: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || src != $past(src)));
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
  import sercom_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16,
  localparam int SW = $clog2(OSR),
  localparam int BW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] din,
  input  logic          short_len,
  input  par_e          par,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  fr_state_e     state;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitn, last;
  logic [DW-1:0] sh, din_m;
  logic          pbit, pen;

  assign din_m = short_len ? {1'b0, din[DW-2:0]} : din;
  assign busy  = (state != FR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FR_IDLE;
      txd   <= 1'b1;
      done  <= 1'b0;
      sub   <= '0;
      bitn  <= '0;
      last  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      pen   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == FR_IDLE) begin
        if (start) begin
          sh    <= din_m;
          last  <= short_len ? BW'(DW - 2) : BW'(DW - 1);
          pbit  <= (par == PAR_ODD) ? ~^din_m : ^din_m;
          pen   <= (par == PAR_EVEN) || (par == PAR_ODD);
          sub   <= '0;
          bitn  <= '0;
          txd   <= 1'b0;
          state <= FR_START;
        end
      end else if (tick) begin
        if (sub != SW'(OSR - 1)) begin
          sub <= sub + 1'b1;
        end else begin
          sub <= '0;
          case (state)
            FR_START: begin
              txd   <= sh[0];
              state <= FR_DATA;
            end
            FR_DATA: begin
              if (bitn == last) begin
                txd   <= pen ? pbit : 1'b1;
                state <= pen ? FR_PAR : FR_STOP;
              end else begin
                bitn <= bitn + 1'b1;
                sh   <= sh >> 1;
                txd  <= sh[1];
              end
            end
            FR_PAR: begin
              txd   <= 1'b1;
              state <= FR_STOP;
            end
            default: begin
              done  <= 1'b1;
              state <= FR_IDLE;
            end
          endcase
        end
      end
    end
  end

  // R1: a new frame opens with the line low
  p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
  // R12: completion is a single-cycle pulse
  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16,
  localparam int SW = $clog2(OSR),
  localparam int BW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd_raw,
  input  logic          short_len,
  input  par_e          par,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr
);
  fr_state_e     state;
  logic [1:0]    sy;
  logic          rs;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitn, last;
  logic [DW-1:0] sh;
  logic          acc, perr_q, pen;

  assign rs   = sy[1];
  assign last = short_len ? BW'(DW - 2) : BW'(DW - 1);
  assign pen  = (par == PAR_EVEN) || (par == PAR_ODD);

  always_ff @(posedge clk) begin
    if (rst) begin
      sy     <= 2'b11;
      state  <= FR_IDLE;
      sub    <= '0;
      bitn   <= '0;
      sh     <= '0;
      acc    <= 1'b0;
      perr_q <= 1'b0;
      valid  <= 1'b0;
      data   <= '0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      sy    <= {sy[0], rxd_raw};
      valid <= 1'b0;
      if (tick) begin
        case (state)
          FR_IDLE: begin
            if (!rs) begin
              sub   <= '0;
              state <= FR_START;
            end
          end
          FR_START: begin
            if (sub != SW'(OSR / 2 - 1)) begin
              sub <= sub + 1'b1;
            end else if (rs) begin
              state <= FR_IDLE;
            end else begin
              sub    <= '0;
              bitn   <= '0;
              acc    <= 1'b0;
              perr_q <= 1'b0;
              state  <= FR_DATA;
            end
          end
          default: begin
            if (sub != SW'(OSR - 1)) begin
              sub <= sub + 1'b1;
            end else begin
              sub <= '0;
              if (state == FR_DATA) begin
                sh  <= {rs, sh[DW-1:1]};
                acc <= acc ^ rs;
                if (bitn == last) state <= pen ? FR_PAR : FR_STOP;
                else bitn <= bitn + 1'b1;
              end else if (state == FR_PAR) begin
                perr_q <= acc ^ rs ^ (par == PAR_ODD);
                state  <= FR_STOP;
              end else begin
                valid <= 1'b1;
                ferr  <= !rs;
                perr  <= pen & perr_q;
                data  <= short_len ? {1'b0, sh[DW-1:1]} : sh;
                state <= FR_IDLE;
              end
            end
          end
        endcase
      end
    end
  end

  // R6: a 7-bit character never carries a set top bit
  p_short_msb_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (valid && short_len) |-> !data[DW-1]);
  // R5: one completion strobe per character
  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/sercom_uart.sv
module sercom_uart
  import sercom_pkg::*;
#(
  parameter int DW      = 8,
  parameter int OSR     = 16,
  parameter int DIV_MAX = 9,
  localparam int EW = $clog2(DIV_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_sclk,
  input  logic          tmr_pulse,
  input  logic          rxd,
  output logic          txd,
  output logic          irq_tx,
  output logic          irq_rx
);
  clk_src_e      src_q;
  par_e          par_q;
  logic          short_q;
  logic [EW-1:0] div_q;
  logic [DW-1:0] tx_hold, rx_buf;
  logic          unread, pe_q, fe_q, ov_q;
  logic          tick, tx_busy, tx_done;
  logic          rx_valid, rx_perr, rx_ferr;
  logic [DW-1:0] rx_data;
  logic          wr_data, wr_mode, wr_div, rd_buf, rd_stat;

  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_mode = bus_wr && (bus_addr == A_MODE);
  assign wr_div  = bus_wr && (bus_addr == A_DIV);
  assign rd_buf  = bus_rd && (bus_addr == A_DATA);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  assign irq_tx  = tx_done;

  sercom_tick #(.DIV_MAX(DIV_MAX)) u_tick (
    .clk(clk), .rst(rst), .src(src_q), .div_exp(div_q),
    .ext_pin(ext_sclk), .tmr_in(tmr_pulse), .tick(tick)
  );

  sercom_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .start(wr_data), .din(bus_wdata),
    .short_len(short_q), .par(par_q), .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  sercom_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd_raw(rxd), .short_len(short_q),
    .par(par_q), .valid(rx_valid), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= SRC_DIV;
      par_q     <= PAR_NONE;
      short_q   <= 1'b0;
      div_q     <= EW'(1);
      tx_hold   <= '1;
      rx_buf    <= '1;
      unread    <= 1'b0;
      pe_q      <= 1'b0;
      fe_q      <= 1'b0;
      ov_q      <= 1'b0;
      irq_rx    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_mode) begin
        src_q   <= clk_src_e'(bus_wdata[1:0]);
        short_q <= bus_wdata[2];
        par_q   <= par_e'(bus_wdata[4:3]);
      end
      if (wr_div) div_q <= bus_wdata[EW-1:0];
      if (wr_data && !tx_busy) tx_hold <= bus_wdata;

      irq_rx <= rx_valid;
      if (rx_valid) begin
        rx_buf <= rx_data;
        unread <= 1'b1;
      end else if (rd_buf) begin
        unread <= 1'b0;
      end
      pe_q <= (pe_q & ~rd_stat) | (rx_valid & rx_perr);
      fe_q <= (fe_q & ~rd_stat) | (rx_valid & rx_ferr);
      ov_q <= (ov_q & ~rd_stat) | (rx_valid & unread & ~rd_buf);

      if (bus_rd) begin
        case (bus_addr)
          A_DATA:  bus_rdata <= rx_buf;
          A_MODE:  bus_rdata <= DW'({par_q, short_q, src_q});
          A_DIV:   bus_rdata <= DW'(div_q);
          default: bus_rdata <= DW'({unread, tx_busy, ov_q, fe_q, pe_q});
        endcase
      end
    end
  end

  // R10: an unread buffer overwritten by a new character flags overrun
  p_ovr_set_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && unread && !rd_buf) |=> ov_q);
  // R8: a status read with no new character clears all error flags
  p_stat_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !rx_valid) |=> (!pe_q && !fe_q && !ov_q));
  // R13: a data write during a frame neither aborts nor restarts it
  p_busy_write_r13: assert property (@(posedge clk) disable iff (rst)
    (wr_data && tx_busy) |=> (tx_busy || tx_done));
endmodule

// File: tb/test_sercom_uart.sv
module test_sercom_uart;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       txd, irq_tx, irq_rx;
  logic       lb = 1'b0, rxd_drv = 1'b1;
  logic [3:0] ext_div = 4'd0;
  logic [1:0] tmr_cnt = 2'd0;
  logic       ext_sclk, tmr_pulse, rxd;
  int         nvec = 0, nfail = 0, nrx = 0, ntx = 0;

  always #10 clk = ~clk;

  assign ext_sclk  = ext_div[1];
  assign tmr_pulse = (tmr_cnt == 2'd0);
  assign rxd       = lb ? txd : rxd_drv;

  always @(negedge clk) begin
    ext_div <= ext_div + 4'd1;
    tmr_cnt <= (tmr_cnt == 2'd2) ? 2'd0 : tmr_cnt + 2'd1;
    if (irq_rx) nrx <= nrx + 1;
    if (irq_tx) ntx <= ntx + 1;
  end

  sercom_uart i_sercom_uart (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_sclk(ext_sclk),
    .tmr_pulse(tmr_pulse), .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  // {mode, divider exponent, tx character, expected receive buffer}
  localparam logic [27:0] VEC [10] = '{
    {8'h00, 4'd1, 8'hA5, 8'hA5},
    {8'h08, 4'd1, 8'h3C, 8'h3C},
    {8'h10, 4'd1, 8'h3C, 8'h3C},
    {8'h0C, 4'd1, 8'hFF, 8'h7F},
    {8'h04, 4'd2, 8'h80, 8'h00},
    {8'h01, 4'd1, 8'h5A, 8'h5A},
    {8'h12, 4'd1, 8'hC3, 8'hC3},
    {8'h14, 4'd3, 8'h01, 8'h01},
    {8'h08, 4'd1, 8'h00, 8'h00},
    {8'h10, 4'd1, 8'hFF, 8'hFF}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int build(input logic [7:0] mode, input logic [7:0] d,
                               output logic [11:0] bits);
    int n, idx;
    logic [7:0] dm;
    n = mode[2] ? 7 : 8;
    dm = mode[2] ? {1'b0, d[6:0]} : d;
    bits = 12'h000;
    idx = 1;
    for (int i = 0; i < n; i++) begin
      bits[idx] = d[i];
      idx = idx + 1;
    end
    if (mode[4:3] == 2'd1) begin bits[idx] = ^dm; idx = idx + 1; end
    else if (mode[4:3] == 2'd2) begin bits[idx] = ~^dm; idx = idx + 1; end
    bits[idx] = 1'b1;
    return idx + 1;
  endfunction

  function automatic int tper(input logic [7:0] mode, input logic [3:0] k);
    if (mode[1:0] == 2'd1) return 4;
    if (mode[1:0] == 2'd2) return 3;
    return 1 << k;
  endfunction

  task automatic drive_bits(input logic [11:0] bits, input int n, input int bitcyc,
                            input int lastcyc);
    for (int i = 0; i < n; i++) begin
      rxd_drv = bits[i];
      repeat ((i == n - 1) ? lastcyc : bitcyc) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic capture_tx(input int t, input int n, output logic [11:0] got);
    int guard = 0;
    got = 12'h000;
    while (txd !== 1'b0 && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    repeat (8 * t) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (16 * t) @(negedge clk);
      got[i] = txd;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0]  rv;
    logic [11:0] bits, got;
    int          n, t, r0, t0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R4: reset state
    check("R4 txd idle", {15'd0, txd}, 16'd1);
    check("R4 irq lines", {14'd0, irq_tx, irq_rx}, 16'd0);
    bus_read(2'd0, rv); check("R4 rx buffer", {8'd0, rv}, 16'h00FF);
    bus_read(2'd3, rv); check("R4 status", {8'd0, rv}, 16'h0000);
    bus_read(2'd2, rv); check("R4 divider", {8'd0, rv}, 16'h0001);

    // R5: directed receive with even parity, divider 2 (bit = 32 cycles)
    bus_write(2'd1, 8'h08);
    n = build(8'h08, 8'h96, bits);
    r0 = nrx;
    drive_bits(bits, n, 32, 32);
    check("R5 one irq_rx pulse", 16'(nrx - r0), 16'd1);
    bus_read(2'd0, rv); check("R5 rx data", {8'd0, rv}, 16'h0096);
    bus_read(2'd3, rv); check("R5 status clean", {8'd0, rv}, 16'h0000);

    // R8: wrong parity bit sets sticky flag, cleared by status read
    bits[n-2] = ~bits[n-2];
    drive_bits(bits, n, 32, 32);
    bus_read(2'd0, rv); check("R8 data still loaded", {8'd0, rv}, 16'h0096);
    bus_read(2'd3, rv); check("R8 parity flag", {8'd0, rv}, 16'h0001);
    bus_read(2'd3, rv); check("R8 flag cleared", {8'd0, rv}, 16'h0000);

    // R9: stop bit low
    bus_write(2'd1, 8'h00);
    n = build(8'h00, 8'h11, bits);
    bits[n-1] = 1'b0;
    drive_bits(bits, n, 32, 24);
    bus_read(2'd0, rv); check("R9 data loaded", {8'd0, rv}, 16'h0011);
    bus_read(2'd3, rv); check("R9 framing flag", {8'd0, rv}, 16'h0002);
    bus_read(2'd3, rv); check("R9 flag cleared", {8'd0, rv}, 16'h0000);

    // R10: two characters without reading the buffer
    n = build(8'h00, 8'h21, bits);
    drive_bits(bits, n, 32, 32);
    n = build(8'h00, 8'h42, bits);
    drive_bits(bits, n, 32, 32);
    bus_read(2'd3, rv); check("R10 overrun+unread", {8'd0, rv}, 16'h0014);
    bus_read(2'd0, rv); check("R10 newest kept", {8'd0, rv}, 16'h0042);
    bus_read(2'd3, rv); check("R10 cleared", {8'd0, rv}, 16'h0000);

    // R11: short low glitch is rejected
    r0 = nrx;
    rxd_drv = 1'b0;
    repeat (6) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (800) @(negedge clk);
    check("R11 no irq_rx", 16'(nrx - r0), 16'd0);
    bus_read(2'd3, rv); check("R11 nothing unread", {8'd0, rv}, 16'h0000);

    // R1 R2 R3 R7 R12 R5 R6: table walk through loopback
    lb = 1'b1;
    for (int v = 0; v < 10; v++) begin
      logic [7:0] mode, d, expv;
      logic [3:0] k;
      {mode, k, d, expv} = VEC[v];
      bus_write(2'd1, mode);
      bus_write(2'd2, {4'd0, k});
      t = tper(mode, k);
      n = build(mode, d, bits);
      t0 = ntx;
      bus_write(2'd0, d);
      capture_tx(t, n, got);
      check($sformatf("R1 R2 R3 R7 frame v%0d", v), {4'd0, got}, {4'd0, bits});
      repeat (16 * t + 20) @(negedge clk);
      check($sformatf("R12 irq_tx v%0d", v), 16'(ntx - t0), 16'd1);
      bus_read(2'd0, rv);
      check($sformatf("R5 R6 rx v%0d", v), {8'd0, rv}, {8'd0, expv});
      bus_read(2'd3, rv);
      check($sformatf("R8 R9 status v%0d", v), {8'd0, rv}, 16'h0000);
    end

    // R12 R13: busy flag and ignored write during a frame
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'h01);
    r0 = nrx;
    t0 = ntx;
    bus_write(2'd0, 8'h55);
    repeat (60) @(negedge clk);
    bus_read(2'd3, rv); check("R12 busy bit", {8'd0, rv}, 16'h0008);
    bus_write(2'd0, 8'hAA);
    repeat (1200) @(negedge clk);
    check("R13 one frame sent", 16'(ntx - t0), 16'd1);
    check("R13 one character received", 16'(nrx - r0), 16'd1);
    bus_read(2'd0, rv); check("R13 first character kept", {8'd0, rv}, 16'h0055);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule